// File: doc/BRIEF.md
# Periodic Time and Calendar Event Flagger

This block sits beside a real-time clock's counters and turns their rollover strobes into sticky status flags. A seconds strobe always raises the second flag. A two-bit time selector picks which instant raises the time flag: a minute change, an hour change, midnight or noon. A two-bit calendar selector picks a week, month or year change for the calendar flag; its fourth code raises nothing. Three more flags (update acknowledge, alarm and free-running error) are set by single-cycle event inputs from neighbouring logic.

Software reads the flags through a small register port and clears them by writing ones to a clear command register. Two further command registers set and clear bits of an interrupt mask, which can be read back. The single interrupt output is high whenever a flag and its mask bit are both set. A flag that is set and cleared in the same cycle stays set.

Top module: `rtc_evt_flags`

## Requirements
- R1: After reset the status flags, the interrupt mask, the control register and `irq` all read 0.
- R2: Each cycle with `sec_tick` high sets status bit 2 on the next clock edge.
- R3: With time selector 0, `min_tick` sets status bit 3; with selector 1, `hour_tick` sets it and `min_tick` does not.
- R4: With time selector 2, `hour_tick` sets status bit 3 only when `hour_now` (the new 24-hour value) is 0; with selector 3, only when `hour_now` is 12.
- R5: Calendar selector 0 sets status bit 4 on `dow_tick` when `dow_now` equals `DOW_FIRST` (default 1); selector 1 sets it on `mon_tick`; selector 2 on `year_tick`.
- R6: Calendar selector 3 never sets status bit 4.
- R7: `upd_ack_evt`, `alarm_evt` and `tderr_evt` set status bits 0, 1 and 5.
- R8: Writing to address 2 clears each status bit whose data bit is 1 and leaves the others; writes to the read-only addresses 1 and 5 change nothing.
- R9: When a set event and a clear command hit the same status bit in one cycle, the bit ends set.
- R10: Writing ones to address 3 sets the matching mask bits, writing ones to address 4 clears them, zeros change nothing; the mask reads at address 5.
- R11: `irq` is high in exactly the cycles where some status bit and its mask bit are both 1.
- R12: Address 0 holds the control register: time selector in bits 1:0, calendar selector in bits 3:2, upper bits read 0; status reads at address 1; addresses 2, 3, 4, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | Seconds changed strobe |
| min_tick | input | 1 | Minutes changed strobe |
| hour_tick | input | 1 | Hours changed strobe |
| dow_tick | input | 1 | Day-of-week changed strobe |
| mon_tick | input | 1 | Month changed strobe |
| year_tick | input | 1 | Year changed strobe |
| hour_now | input | 5 | Current hour, 24-hour count, new value during `hour_tick` |
| dow_now | input | 3 | Current day of week, new value during `dow_tick` |
| upd_ack_evt | input | 1 | Update acknowledge event |
| alarm_evt | input | 1 | Alarm event |
| tderr_evt | input | 1 | Free-running error event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | DW (32) | Register write data |
| rd_addr | input | AW (3) | Register read address |
| rd_data | output | DW (32) | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the strobes and event inputs as single-cycle pulses sampled on the rising edge, and take `hour_now` and `dow_now` as already holding the new value in a strobe's cycle. They also take the single write port as never issuing mask set and mask clear in the same cycle. The stimulus changes inputs only on the falling edge and keeps `hour_now` in 0..23. Its random phase draws every strobe and every write address freely, including the read-only and unused ones, so clear commands land on bits that are being set in the same cycle.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int ST_W   = 6;
  localparam int HOUR_W = 5;
  localparam int DOW_W  = 3;
  localparam int SEL_W  = 2;

  localparam int ST_ACK = 0;
  localparam int ST_ALM = 1;
  localparam int ST_SEC = 2;
  localparam int ST_TIM = 3;
  localparam int ST_CAL = 4;
  localparam int ST_ERR = 5;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CLR  = 2;
  localparam int A_MSET = 3;
  localparam int A_MCLR = 4;
  localparam int A_MASK = 5;

  typedef enum logic [SEL_W-1:0] {
    TS_MINUTE   = 2'd0,
    TS_HOUR     = 2'd1,
    TS_MIDNIGHT = 2'd2,
    TS_NOON     = 2'd3
  } tsel_e;

  typedef enum logic [SEL_W-1:0] {
    CS_WEEK  = 2'd0,
    CS_MONTH = 2'd1,
    CS_YEAR  = 2'd2,
    CS_RSVD  = 2'd3
  } csel_e;

  function automatic logic time_hit_f(tsel_e sel, logic min_t, logic hour_t,
                                      logic [HOUR_W-1:0] hr);
    logic r;
    unique case (sel)
      TS_MINUTE:   r = min_t;
      TS_HOUR:     r = hour_t;
      TS_MIDNIGHT: r = hour_t && (hr == HOUR_W'(0));
      default:     r = hour_t && (hr == HOUR_W'(12));
    endcase
    return r;
  endfunction

  function automatic logic cal_hit_f(csel_e sel, logic dow_t, logic [DOW_W-1:0] dow,
                                     logic [DOW_W-1:0] dow_first, logic mon_t, logic year_t);
    logic r;
    unique case (sel)
      CS_WEEK:  r = dow_t && (dow == dow_first);
      CS_MONTH: r = mon_t;
      CS_YEAR:  r = year_t;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_evt_decode.sv
module rtc_evt_decode
  import rtc_evt_pkg::*;
#(
  parameter int DOW_FIRST = 1
) (
  input  tsel_e             tsel,
  input  csel_e             csel,
  input  logic              sec_tick,
  input  logic              min_tick,
  input  logic              hour_tick,
  input  logic              dow_tick,
  input  logic              mon_tick,
  input  logic              year_tick,
  input  logic [HOUR_W-1:0] hour_now,
  input  logic [DOW_W-1:0]  dow_now,
  input  logic              upd_ack_evt,
  input  logic              alarm_evt,
  input  logic              tderr_evt,
  output logic              time_hit,
  output logic              cal_hit,
  output logic [ST_W-1:0]   set_vec
);
  localparam logic [DOW_W-1:0] DOW_FIRST_V = DOW_W'(DOW_FIRST);

  assign time_hit = time_hit_f(tsel, min_tick, hour_tick, hour_now);
  assign cal_hit  = cal_hit_f(csel, dow_tick, dow_now, DOW_FIRST_V, mon_tick, year_tick);

  always_comb begin
    set_vec         = '0;
    set_vec[ST_ACK] = upd_ack_evt;
    set_vec[ST_ALM] = alarm_evt;
    set_vec[ST_SEC] = sec_tick;
    set_vec[ST_TIM] = time_hit;
    set_vec[ST_CAL] = cal_hit;
    set_vec[ST_ERR] = tderr_evt;
  end
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status
  import rtc_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  output logic [ST_W-1:0] status
);
  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;
      else if (clr_vec[i]) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_evt_mask.sv
module rtc_evt_mask
  import rtc_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] en_vec,
  input  logic [ST_W-1:0] dis_vec,
  input  logic [ST_W-1:0] status,
  output logic [ST_W-1:0] mask,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask & ~dis_vec) | en_vec;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_evt_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int DOW_FIRST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              min_tick,
  input  logic              hour_tick,
  input  logic              dow_tick,
  input  logic              mon_tick,
  input  logic              year_tick,
  input  logic [HOUR_W-1:0] hour_now,
  input  logic [DOW_W-1:0]  dow_now,
  input  logic              upd_ack_evt,
  input  logic              alarm_evt,
  input  logic              tderr_evt,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int CTRL_W = 2 * SEL_W;

  tsel_e           tsel;
  csel_e           csel;
  logic            time_hit;
  logic            cal_hit;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] clr_vec;
  logic [ST_W-1:0] en_vec;
  logic [ST_W-1:0] dis_vec;
  logic [ST_W-1:0] status;
  logic [ST_W-1:0] mask;
  logic            wr_ctrl;
  logic            unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DW-1:CTRL_W];

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign clr_vec = (wr_en && (wr_addr == AW'(A_CLR)))  ? wr_data[ST_W-1:0] : '0;
  assign en_vec  = (wr_en && (wr_addr == AW'(A_MSET))) ? wr_data[ST_W-1:0] : '0;
  assign dis_vec = (wr_en && (wr_addr == AW'(A_MCLR))) ? wr_data[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsel <= TS_MINUTE;
      csel <= CS_WEEK;
    end else if (wr_ctrl) begin
      tsel <= tsel_e'(wr_data[SEL_W-1:0]);
      csel <= csel_e'(wr_data[CTRL_W-1:SEL_W]);
    end
  end

  rtc_evt_decode #(.DOW_FIRST(DOW_FIRST)) u_decode (
    .tsel        (tsel),
    .csel        (csel),
    .sec_tick    (sec_tick),
    .min_tick    (min_tick),
    .hour_tick   (hour_tick),
    .dow_tick    (dow_tick),
    .mon_tick    (mon_tick),
    .year_tick   (year_tick),
    .hour_now    (hour_now),
    .dow_now     (dow_now),
    .upd_ack_evt (upd_ack_evt),
    .alarm_evt   (alarm_evt),
    .tderr_evt   (tderr_evt),
    .time_hit    (time_hit),
    .cal_hit     (cal_hit),
    .set_vec     (set_vec)
  );

  rtc_evt_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status)
  );

  rtc_evt_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_vec  (en_vec),
    .dis_vec (dis_vec),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      AW'(A_CTRL): rd_data[CTRL_W-1:0] = {csel, tsel};
      AW'(A_STAT): rd_data[ST_W-1:0]   = status;
      AW'(A_MASK): rd_data[ST_W-1:0]   = mask;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_evt_flags_chk.sv
module rtc_evt_flags_chk
  import rtc_evt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sec_tick,
  input logic            cal_hit,
  input logic [1:0]      csel_raw,
  input logic [ST_W-1:0] set_vec,
  input logic [ST_W-1:0] clr_vec,
  input logic [ST_W-1:0] en_vec,
  input logic [ST_W-1:0] dis_vec,
  input logic [ST_W-1:0] status,
  input logic [ST_W-1:0] mask
);
  a_r2_sec_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> status[ST_SEC]);

  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_raw == 2'd3) |-> !cal_hit);

  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

  a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  a_r10_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_vec) |=> ((mask & $past(en_vec)) == $past(en_vec)));

  a_r10_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (|dis_vec) |=> ((mask & $past(dis_vec)) == '0));
endmodule

bind rtc_evt_flags rtc_evt_flags_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .cal_hit  (cal_hit),
  .csel_raw (csel),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .en_vec   (en_vec),
  .dis_vec  (dis_vec),
  .status   (status),
  .mask     (mask)
);

// File: tb/rtc_evt_flags_tb.sv
module rtc_evt_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_t = 0, min_t = 0, hour_t = 0, dow_t = 0, mon_t = 0, year_t = 0;
  logic [4:0]  hour_now = 0;
  logic [2:0]  dow_now = 0;
  logic        ack_e = 0, alm_e = 0, err_e = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] m_stat = 0, m_mask = 0;
  logic [1:0] m_tsel = 0, m_csel = 0;

  always #5 clk = ~clk;

  rtc_evt_flags u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_t), .min_tick(min_t), .hour_tick(hour_t),
    .dow_tick(dow_t), .mon_tick(mon_t), .year_tick(year_t), .hour_now(hour_now),
    .dow_now(dow_now), .upd_ack_evt(ack_e), .alarm_evt(alm_e), .tderr_evt(err_e),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [5:0] exp_set(logic [1:0] ts, logic [1:0] cs);
    logic [5:0] v = 6'b0;
    logic tim = 0, cal = 0;
    if (ts == 2'd0) tim = min_t;
    if (ts == 2'd1) tim = hour_t;
    if (ts == 2'd2 && hour_now == 5'd0)  tim = hour_t;
    if (ts == 2'd3 && hour_now == 5'd12) tim = hour_t;
    if (cs == 2'd0) cal = dow_t & (dow_now == 3'd1);
    if (cs == 2'd1) cal = mon_t;
    if (cs == 2'd2) cal = year_t;
    v = {err_e, cal, tim, sec_t, alm_e, ack_e};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cyc();
    @(negedge clk);
    {sec_t, min_t, hour_t, dow_t, mon_t, year_t, ack_e, alm_e, err_e} = '0;
    wr_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic chk_stat(string tag, logic [5:0] exp);
    logic [31:0] v;
    rd(3'd1, v);
    check(tag, v, {26'b0, exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd1, v); check("R1 status", v, 0);
    rd(3'd5, v); check("R1 mask", v, 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R12 control register layout and read map
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, v); check("R12 ctrl readback", v, 32'hE);
    rd(3'd2, v); check("R12 clear reads 0", v, 0);
    rd(3'd7, v); check("R12 unused reads 0", v, 0);
    wr(3'd0, 32'h0);
    // R2 second event
    sec_t = 1; cyc(); chk_stat("R2 sec", 6'h04);
    wr(3'd2, 32'h04); chk_stat("R8 clear sec", 6'h00);
    // R3 minute / hour
    min_t = 1; cyc(); chk_stat("R3 minute sel0", 6'h08);
    wr(3'd2, 32'h08);
    wr(3'd0, 32'h1);
    min_t = 1; cyc(); chk_stat("R3 minute ignored sel1", 6'h00);
    hour_t = 1; hour_now = 5'd7; cyc(); chk_stat("R3 hour sel1", 6'h08);
    wr(3'd2, 32'h08);
    // R4 midnight / noon
    wr(3'd0, 32'h2);
    hour_t = 1; hour_now = 5'd12; cyc(); chk_stat("R4 midnight not at 12", 6'h00);
    hour_t = 1; hour_now = 5'd0;  cyc(); chk_stat("R4 midnight", 6'h08);
    wr(3'd2, 32'h08);
    wr(3'd0, 32'h3);
    hour_t = 1; hour_now = 5'd0;  cyc(); chk_stat("R4 noon not at 0", 6'h00);
    hour_t = 1; hour_now = 5'd12; cyc(); chk_stat("R4 noon", 6'h08);
    wr(3'd2, 32'h08);
    // R5 calendar events
    wr(3'd0, 32'h0);
    dow_t = 1; dow_now = 3'd4; mon_t = 1; cyc(); chk_stat("R5 week not first", 6'h00);
    dow_t = 1; dow_now = 3'd1; cyc(); chk_stat("R5 week wrap", 6'h10);
    wr(3'd2, 32'h10);
    wr(3'd0, 32'h4);
    year_t = 1; cyc(); chk_stat("R5 year ignored sel month", 6'h00);
    mon_t = 1; cyc(); chk_stat("R5 month", 6'h10);
    wr(3'd2, 32'h10);
    wr(3'd0, 32'h8);
    year_t = 1; cyc(); chk_stat("R5 year", 6'h10);
    wr(3'd2, 32'h10);
    // R6 reserved calendar code
    wr(3'd0, 32'hC);
    dow_t = 1; dow_now = 3'd1; mon_t = 1; year_t = 1; cyc();
    chk_stat("R6 reserved no event", 6'h00);
    // R7 external events
    ack_e = 1; alm_e = 1; err_e = 1; cyc(); chk_stat("R7 external", 6'h23);
    // R8 partial clear and read-only writes
    wr(3'd2, 32'h02); chk_stat("R8 partial clear", 6'h21);
    wr(3'd1, 32'h3F); chk_stat("R8 status write ignored", 6'h21);
    // R9 set wins
    alm_e = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 32'h23; cyc();
    chk_stat("R9 set wins", 6'h02);
    // R10/R11 mask and irq
    check("R11 irq masked off", {31'b0, irq}, 0);
    wr(3'd3, 32'h02); rd(3'd5, v); check("R10 mask set", v, 32'h02);
    check("R11 irq on", {31'b0, irq}, 1);
    wr(3'd3, 32'h00); rd(3'd5, v); check("R10 zero enable no effect", v, 32'h02);
    wr(3'd5, 32'h00); rd(3'd5, v); check("R10 mask write ignored", v, 32'h02);
    wr(3'd4, 32'h02); rd(3'd5, v); check("R10 mask clear", v, 32'h00);
    check("R11 irq off", {31'b0, irq}, 0);
    wr(3'd2, 32'h3F);
    wr(3'd0, 32'h0);

    // random phase against bench model
    m_stat = 0; m_mask = 0; m_tsel = 0; m_csel = 0;
    void'($urandom(32'd12345));
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] s;
      rd(3'd1, v); check("R8 random status", v, {26'b0, m_stat});
      rd(3'd5, v); check("R10 random mask", v, {26'b0, m_mask});
      check("R11 random irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
      {sec_t, min_t, hour_t, dow_t, mon_t, year_t} = 6'($urandom) & 6'($urandom);
      {ack_e, alm_e, err_e} = 3'($urandom) & 3'($urandom) & 3'($urandom);
      hour_now = 5'($urandom_range(0, 23));
      dow_now = 3'($urandom);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = 3'($urandom);
      wr_data = $urandom;
      s = exp_set(m_tsel, m_csel);
      if (wr_en && wr_addr == 3'd2) m_stat = m_stat & ~wr_data[5:0];
      m_stat = m_stat | s;
      if (wr_en && wr_addr == 3'd3) m_mask = m_mask | wr_data[5:0];
      if (wr_en && wr_addr == 3'd4) m_mask = m_mask & ~wr_data[5:0];
      if (wr_en && wr_addr == 3'd0) begin
        m_tsel = wr_data[1:0];
        m_csel = wr_data[3:2];
      end
      cyc();
    end
    rd(3'd0, v); check("R12 random ctrl", v, {28'b0, m_csel, m_tsel});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule